// File: doc/BRIEF.md
# Two-Plane Hardware Cursor Overlay

This block lays a 64x64 monochrome cursor over a 32-bit pixel stream as it is scanned out. At the start of each scanline it decides whether that line crosses the cursor. If it does, it issues one request for the 16-byte bitmap row. The row holds a 64-bit AND plane followed by a 64-bit XOR plane. As pixels then flow through, each pixel covered by the cursor is replaced, inverted or left alone, depending on its pair of mask bits.

The cursor position, the bitmap offset, the hot-spot offsets and the two colours go through a working copy. That copy follows the configuration inputs every cycle. While the lock bit (bit 31 of the offset input) is high, the copy is held. When the lock drops, the current configuration is picked up again. The enable bit is not held by the lock. The output pixel is registered and appears one cycle after the input pixel.

Top module: `cursor_overlay`

## Requirements
- R1: While reset is held and right after it, `pix_out` is zero and `pix_out_vld` and `fetch_req` are low.
- R2: On a line hit, `fetch_addr` equals `{1'b0, offset[30:0]} - hot_x - 16*hot_y + 16*row`. Here `row` is the line number minus the cursor Y, `hot_x` is `cfg_hot[21:16]` and `hot_y` is `cfg_hot[5:0]`. `fetch_req` pulses for one cycle, one cycle after `line_start`.
- R3: In `fetch_data`, byte k sits at bits [8k+7:8k]. Bytes 0..7 are the AND plane and bytes 8..15 are the XOR plane. Cursor column c uses bit 7-(c mod 8) of byte c/8 in each plane.
- R4: A covered pixel whose AND bit is 1 and XOR bit is 1 comes out as the bitwise complement of the input pixel.
- R5: A covered pixel whose AND bit is 1 and XOR bit is 0 comes out unchanged.
- R6: A covered pixel whose AND bit is 0 comes out as `{colour1, 8'hFF}` when its XOR bit is 1, and as `{colour0, 8'hFF}` when its XOR bit is 0.
- R7: A line is hit only when Y <= line <= Y+63 and line <= `v_disp`. On any other line no fetch is made and every pixel passes through.
- R8: Columns X..X+63 are covered only while `pix_x < (h_disp+1)*8`. Pixels at or beyond that width pass through, and the cursor never wraps onto the next line.
- R9: While `cfg_offset[31]` is high at a clock edge, the working position, offset, hot-spot and colours keep their values. A line request issued on the edge where the lock drops still uses the held values. The next edge picks up the new configuration.
- R10: With `cur_en` low, no fetch is issued and every pixel passes through unchanged.
- R11: `pix_out` and `pix_out_vld` follow `pix_in` and `pix_vld` with exactly one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cur_en | input | 1 | Cursor enable |
| cfg_pos | input | 32 | Cursor X in [31:16], cursor Y in [15:0] |
| cfg_offset | input | 32 | Bitmap offset in [30:0]; bit 31 is the update lock |
| cfg_hot | input | 32 | Hot-spot X in [21:16], hot-spot Y in [5:0] |
| cfg_color0 | input | 24 | RGB colour for AND=0, XOR=0 |
| cfg_color1 | input | 24 | RGB colour for AND=0, XOR=1 |
| h_disp | input | 11 | Horizontal display field; active width is (h_disp+1)*8 |
| v_disp | input | 16 | Last displayed line number |
| line_start | input | 1 | Pulse marking the start of scanline `line_num` |
| line_num | input | 16 | Current scanline number |
| fetch_req | output | 1 | Request for one 16-byte bitmap row |
| fetch_addr | output | 32 | Byte address of the requested row |
| fetch_vld | input | 1 | Returned row is valid |
| fetch_data | input | 128 | Returned row, byte 0 in the low bits |
| pix_vld | input | 1 | Input pixel valid |
| pix_x | input | 16 | Column of the input pixel |
| pix_in | input | 32 | Input pixel |
| pix_out_vld | output | 1 | Output pixel valid |
| pix_out | output | 32 | Output pixel with the cursor applied |

## Verification
Two functions can fall on the same clock edge: the release of the update lock and the line request. The bench provokes this by dropping `cfg_offset[31]` in the same cycle as `line_start`. In that cycle the position and offset inputs already carry new values. The request address is judged against the held values. The following line is then judged against the new position and address, and its pixels are checked at the new X. A second overlap occurs at the right edge, where the display width cuts the cursor part way through a mask pattern. Each pixel there is checked against a model that applies the width test before the mask decode.

// File: rtl/cursor_overlay.sv
module cursor_overlay #(
  parameter int CUR_DIM = 64,
  parameter int PIX_W   = 32,
  parameter int COL_W   = 24,
  parameter int CRD_W   = 16,
  parameter int ADR_W   = 32,
  parameter int HD_W    = 11
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cur_en,
  input  logic [31:0]          cfg_pos,
  input  logic [31:0]          cfg_offset,
  input  logic [31:0]          cfg_hot,
  input  logic [COL_W-1:0]     cfg_color0,
  input  logic [COL_W-1:0]     cfg_color1,
  input  logic [HD_W-1:0]      h_disp,
  input  logic [CRD_W-1:0]     v_disp,
  input  logic                 line_start,
  input  logic [CRD_W-1:0]     line_num,
  output logic                 fetch_req,
  output logic [ADR_W-1:0]     fetch_addr,
  input  logic                 fetch_vld,
  input  logic [2*CUR_DIM-1:0] fetch_data,
  input  logic                 pix_vld,
  input  logic [CRD_W-1:0]     pix_x,
  input  logic [PIX_W-1:0]     pix_in,
  output logic                 pix_out_vld,
  output logic [PIX_W-1:0]     pix_out
);
  localparam int RB      = $clog2(CUR_DIM);
  localparam int ROW_B   = 2 * CUR_DIM / 8;
  localparam int FILL_W  = PIX_W - COL_W;

  logic [31:0]      a_pos, a_off, a_hot;
  logic [COL_W-1:0] a_c0, a_c1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      a_pos <= '0; a_off <= '0; a_hot <= '0; a_c0 <= '0; a_c1 <= '0;
    end else if (!cfg_offset[31]) begin
      a_pos <= cfg_pos; a_off <= cfg_offset; a_hot <= cfg_hot;
      a_c0  <= cfg_color0; a_c1 <= cfg_color1;
    end

  wire [CRD_W-1:0] cx = a_pos[31:16];
  wire [CRD_W-1:0] cy = a_pos[15:0];
  wire [CRD_W-1:0] row = line_num - cy;
  wire line_hit = cur_en && (line_num >= cy) && (row < CRD_W'(CUR_DIM)) && (line_num <= v_disp);
  wire [ADR_W-1:0] base = {1'b0, a_off[30:0]} - ADR_W'(a_hot[21:16]) - (ADR_W'(a_hot[5:0]) << 4);
  wire [ADR_W-1:0] row_addr = base + ADR_W'(row[RB-1:0]) * ADR_W'(ROW_B);

  logic pend, line_act;
  logic [CUR_DIM-1:0] and_q, xor_q, and_d, xor_d;

  for (genvar g = 0; g < CUR_DIM; g++) begin : g_unpack
    assign and_d[g] = fetch_data[8*(g/8) + 7 - (g%8)];
    assign xor_d[g] = fetch_data[CUR_DIM + 8*(g/8) + 7 - (g%8)];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      fetch_req <= 1'b0; fetch_addr <= '0; pend <= 1'b0; line_act <= 1'b0;
      and_q <= '0; xor_q <= '0;
    end else begin
      fetch_req <= line_start && line_hit;
      if (line_start) begin
        fetch_addr <= row_addr;
        pend       <= line_hit;
        line_act   <= 1'b0;
      end else if (pend && fetch_vld) begin
        pend     <= 1'b0;
        line_act <= 1'b1;
        and_q    <= and_d;
        xor_q    <= xor_d;
      end
    end

  wire [CRD_W-1:0] width = CRD_W'((32'(h_disp) + 32'd1) * 32'd8);
  wire [CRD_W-1:0] col   = pix_x - cx;
  wire covered = cur_en && line_act && (pix_x >= cx) && (col < CRD_W'(CUR_DIM)) && (pix_x < width);
  wire m_and = and_q[col[RB-1:0]];
  wire m_xor = xor_q[col[RB-1:0]];
  wire [PIX_W-1:0] fill = {(m_xor ? a_c1 : a_c0), {FILL_W{1'b1}}};
  wire [PIX_W-1:0] nxt  = !covered ? pix_in : m_and ? (m_xor ? ~pix_in : pix_in) : fill;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pix_out <= '0; pix_out_vld <= 1'b0;
    end else begin
      pix_out <= nxt; pix_out_vld <= pix_vld;
    end

  p_lock_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_offset[31] |=> ($stable(a_pos) && $stable(a_off) && $stable(a_c0) && $stable(a_c1)));
  p_no_fetch_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && !cur_en) |=> !fetch_req);
  p_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pix_vld |=> pix_out_vld);
  p_idle_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_act && !line_start) |=> (pix_out == $past(pix_in)));
  p_edge_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_x >= width) |=> (pix_out == $past(pix_in)));
  p_req_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |=> !fetch_req);
endmodule

// File: tb/cursor_overlay_tb.sv
module cursor_overlay_tb_top;
  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic cur_en = 0, line_start = 0, fetch_vld = 0, pix_vld = 0;
  logic [31:0] cfg_pos = 0, cfg_offset = 0, cfg_hot = 0, pix_in = 0;
  logic [23:0] cfg_color0 = 0, cfg_color1 = 0;
  logic [10:0] h_disp = 11'd79;
  logic [15:0] v_disp = 16'd479, line_num = 0, pix_x = 0;
  logic [127:0] fetch_data = 0;
  logic fetch_req, pix_out_vld;
  logic [31:0] fetch_addr, pix_out;

  cursor_overlay dut_i (.clk, .rst_n, .cur_en, .cfg_pos, .cfg_offset, .cfg_hot,
    .cfg_color0, .cfg_color1, .h_disp, .v_disp, .line_start, .line_num,
    .fetch_req, .fetch_addr, .fetch_vld, .fetch_data, .pix_vld, .pix_x,
    .pix_in, .pix_out_vld, .pix_out);

  int n_chk = 0, n_bad = 0;
  logic [63:0] aw = 64'hF0F0_F0F0_0F0F_0F0F, xw = 64'hCCCC_CCCC_3333_3333;
  int rx = 100, rw = 640;
  logic [23:0] rc0, rc1;
  bit rhit;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] pack(logic [63:0] a, logic [63:0] x);
    logic [127:0] d;
    for (int i = 0; i < 8; i++) begin
      d[8*i +: 8]      = a[63-8*i -: 8];
      d[64 + 8*i +: 8] = x[63-8*i -: 8];
    end
    return d;
  endfunction

  function automatic logic [31:0] model(int x, logic [31:0] p);
    int c = x - rx;
    if (!rhit || c < 0 || c > 63 || x >= rw) return p;
    if (aw[63-c]) return xw[63-c] ? ~p : p;
    return {(xw[63-c] ? rc1 : rc0), 8'hFF};
  endfunction

  task automatic run_line(logic [15:0] ln, bit exp_hit, logic [31:0] exp_addr, string req);
    line_num = ln; line_start = 1;
    @(negedge clk) line_start = 0;
    chk({req, " fetch_req"}, {31'd0, fetch_req}, {31'd0, exp_hit});
    if (exp_hit) chk({req, " R2 fetch_addr"}, fetch_addr, exp_addr);
    rhit = exp_hit && cur_en;
    fetch_data = pack(aw, xw); fetch_vld = 1;
    @(negedge clk) fetch_vld = 0;
  endtask

  task automatic scan(int x0, int x1, string req);
    for (int x = x0; x <= x1; x++) begin
      logic [31:0] p = 32'h1357_9BDF ^ (x * 32'h0101_0103);
      pix_x = 16'(x); pix_in = p; pix_vld = 1;
      @(negedge clk);
      chk({req, " R11 vld"}, {31'd0, pix_out_vld}, 32'd1);
      chk(req, pix_out, model(x, p));
    end
    pix_vld = 0;
  endtask

  task automatic t_reset();
    chk("R1 pix_out", pix_out, 0);
    chk("R1 fetch_req", {31'd0, fetch_req}, 0);
    chk("R1 vld", {31'd0, pix_out_vld}, 0);
    @(negedge clk) rst_n = 1;
    @(negedge clk);
  endtask

  task automatic t_masks();
    run_line(16'd55, 1, 32'h402D, "R2");
    scan(96, 168, "R3 R4 R5 R6 masks");
    aw = 64'h0123_4567_89AB_CDEF; xw = 64'hFEDC_BA98_7654_3210;
    run_line(16'd50, 1, 32'h3FDD, "R2 row0");
    scan(98, 166, "R3 R4 R5 R6 pattern2");
    aw = 64'hF0F0_F0F0_0F0F_0F0F; xw = 64'hCCCC_CCCC_3333_3333;
  endtask

  task automatic t_vwin();
    run_line(16'd49, 0, 0, "R7 above");
    scan(100, 104, "R7 above pass");
    run_line(16'd113, 1, 32'h3FDD + 63*16, "R7 last row");
    scan(100, 104, "R7 last row pix");
    run_line(16'd114, 0, 0, "R7 below");
    scan(100, 104, "R7 below pass");
    v_disp = 16'd60;
    run_line(16'd60, 1, 32'h3FDD + 10*16, "R7 at vdisp");
    run_line(16'd61, 0, 0, "R7 past vdisp");
    scan(100, 104, "R7 past vdisp pass");
    v_disp = 16'd479;
  endtask

  task automatic t_edge();
    h_disp = 11'd19; rw = 160;
    run_line(16'd60, 1, 32'h3FDD + 10*16, "R8");
    scan(150, 170, "R8 clip");
    h_disp = 11'd79; rw = 640;
  endtask

  task automatic t_disable();
    cur_en = 0;
    run_line(16'd55, 0, 0, "R10 off");
    scan(100, 110, "R10 pass");
    cur_en = 1;
  endtask

  task automatic t_lock();
    cfg_offset = 32'h8000_4000;
    @(negedge clk);
    cfg_pos = {16'd200, 16'd70}; cfg_offset = 32'h8000_8000;
    cfg_color0 = 24'h445566;
    @(negedge clk);
    run_line(16'd55, 1, 32'h402D, "R9 held");
    scan(98, 104, "R9 held pix");
    cfg_offset = 32'h0000_8000;
    run_line(16'd75, 1, 32'h3FDD + 25*16, "R9 same edge");
    rx = 200; rc0 = 24'h445566;
    run_line(16'd75, 1, 32'h7FDD + 5*16, "R9 released");
    scan(196, 206, "R9 new pos");
  endtask

  initial begin
    cfg_pos = {16'd100, 16'd50}; cfg_offset = 32'h0000_4000;
    cfg_hot = {10'd0, 6'd3, 10'd0, 6'd2};
    cfg_color0 = 24'h112233; cfg_color1 = 24'hA0B0C0;
    rc0 = 24'h112233; rc1 = 24'hA0B0C0;
    @(negedge clk);
    t_reset();
    cur_en = 1;
    @(negedge clk);
    t_masks();
    t_vwin();
    t_edge();
    t_disable();
    t_lock();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule